// File: doc/BRIEF.md
# Vectored Priority Interrupt Collector

This block gathers 64 interrupt request lines into a single IRQ line for a processor. Each source carries a small configuration field with a two-bit priority level, an enable and a software-trigger bit. Among the sources that are enabled and requesting, the collector picks one winner. It reports that winner's number, and it forms a vector address from a programmable table base so that the handler can branch straight to the right routine.

The collector also supports nesting by priority level. It keeps one in-service flag per level. A handler enters service either by writing the vector register or, in a selectable mode, by reading it. The handler ends service by writing that level's bit to a level-acknowledge register. A higher-priority request can still interrupt a handler that is running at a lower level, unless nesting is switched off. Software reaches every register through a 32-bit word bus. Every writable register has four aliases: one writes the value, one sets bits, one clears bits and one toggles bits.

Top module: `irq_collector`

## Requirements
- R1: After reset every source field, the control word, the table base, the scratch word and the in-service flags read zero, the status reads 0 and `irq_out` is low.
- R2: Bus word address bits [1:0] select the access alias of a register: 0 writes the value, 1 ORs the data in, 2 clears the bits set in the data, 3 XORs the data in. This holds for the control word, the source fields, the table base and the scratch word.
- R3: The field of source n is byte n mod 4 of the word at byte offset 0x060 + 0x10*(n/4). Its bits [1:0] hold the priority, bit 2 the enable and bit 3 the software trigger. Bits [7:4] of each byte read zero.
- R4: Byte offsets 0x040 and 0x050 read the unfiltered request lines 0-31 and 32-63, whatever the enables are.
- R5: A source becomes pending one cycle after its enable is set together with its request line or its software trigger. The winner is the pending source with the highest priority, and a tie goes to the lowest source number. Once `irq_out` is up, the status at 0x030 reports the winner in bits [5:0].
- R6: Writing a 1 to bit n mod 32 at 0x1D0 (sources 0-31) or at 0x1E0 (sources 32-63) drops any latched pending state of source n. A one-cycle request that was dropped this way leaves `irq_out` low.
- R7: The table base is written at 0x160, where bits [1:0] read zero. The vector register at 0x000 reads the table base plus 4 times the active source number.
- R8: When control bit 18 is 0, a write to the vector register while `irq_out` is high puts the active source's level in service. When bit 18 is 1, a read does this and a write has no effect. The in-service flags read back at 0x010, with bit L standing for level L.
- R9: `irq_out` is high only while control bit 16 is set and a pending source has a level above every level in service.
- R10: When control bit 19 is set, `irq_out` stays low while any level is in service.
- R11: Writing ones to 0x010 clears the in-service flags of those levels, which lets the next request at that level or a lower one through.
- R12: The status and vector registers change only while `irq_out`'s condition holds. While a request is blocked, they keep showing the source that last held the line.
- R13: Byte offset 0x1F0 is a read/write scratch word with no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (used only for the read side effect) |
| bus_addr | input | 7 | Word address: byte offset divided by 4 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| req_in | input | 64 | Raw interrupt request lines |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Four kinds of pattern drive the main function. The first is a sweep that raises one request line at a time across all 64 sources, each with its own priority. It shows whether the source number reaches the status and vector registers correctly for every field position. The second places several software-triggered sources of mixed and equal priority at once and then removes the winners one by one. This separates priority ordering from index order and confirms the lowest-index tie-break. The third is a sequence of nested entry and acknowledge steps, run in both entry modes and with nesting on and off. It shows whether preemption is allowed only above the highest level in service and whether the reported source is held while a request is blocked. The fourth covers one-cycle request pulses followed by writes to the drop registers, which shows that latched state is discarded.

// File: rtl/icoll_pkg.sv
package icoll_pkg;

  // Word address is byte offset >> 2; block number is byte offset >> 4.
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BLK_W  = ADDR_W - 2;

  typedef enum logic [1:0] {
    ACC_WRITE = 2'd0,
    ACC_SET   = 2'd1,
    ACC_CLEAR = 2'd2,
    ACC_FLIP  = 2'd3
  } acc_mode_e;

  localparam logic [BLK_W-1:0] BLK_VECTOR  = 5'h00;
  localparam logic [BLK_W-1:0] BLK_LVLACK  = 5'h01;
  localparam logic [BLK_W-1:0] BLK_CTRL    = 5'h02;
  localparam logic [BLK_W-1:0] BLK_STAT    = 5'h03;
  localparam logic [BLK_W-1:0] BLK_RAW_LO  = 5'h04;
  localparam logic [BLK_W-1:0] BLK_RAW_HI  = 5'h05;
  localparam logic [BLK_W-1:0] BLK_CFG0    = 5'h06;
  localparam logic [BLK_W-1:0] BLK_VBASE   = 5'h16;
  localparam logic [BLK_W-1:0] BLK_DROP_LO = 5'h1D;
  localparam logic [BLK_W-1:0] BLK_SCRATCH = 5'h1F;

  localparam int unsigned CTRL_IRQ_EN_BIT  = 16;
  localparam int unsigned CTRL_RD_ACK_BIT  = 18;
  localparam int unsigned CTRL_NO_NEST_BIT = 19;

  localparam logic [31:0] CTRL_MASK  = 32'h000D_0000;
  localparam logic [31:0] CFG_MASK   = 32'h0F0F_0F0F;
  localparam logic [31:0] VBASE_MASK = 32'hFFFF_FFFC;

  function automatic logic [31:0] acc_apply(input logic [31:0] cur,
                                            input logic [31:0] wd,
                                            input acc_mode_e   mode);
    logic [31:0] res;
    unique case (mode)
      ACC_WRITE: res = wd;
      ACC_SET:   res = cur | wd;
      ACC_CLEAR: res = cur & ~wd;
      default:   res = cur ^ wd;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/icoll_regfile.sv
module icoll_regfile
  import icoll_pkg::*;
#(
  parameter int unsigned NSRC = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  output logic [NSRC-1:0][3:0]  cfg_o,
  output logic                  irq_en_o,
  output logic                  rd_mode_o,
  output logic                  no_nest_o,
  output logic [31:2]           vbase_o,
  output logic [31:0]           rdata_o,
  output logic                  hit_o
);

  localparam int unsigned NWORD = NSRC / 4;

  logic [BLK_W-1:0] blk;
  acc_mode_e        mode;

  assign blk  = addr[ADDR_W-1:2];
  assign mode = acc_mode_e'(addr[1:0]);

  // per-word source configuration storage
  logic [31:0] word_q [NWORD];
  logic [31:0] word_d [NWORD];
  logic [NWORD-1:0] word_we;

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    assign word_we[w] = wr_en && (blk == BLK_CFG0 + BLK_W'(w));

    always_comb begin
      word_d[w] = acc_apply(word_q[w], wdata, mode) & CFG_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[w] <= '0;
      end else if (word_we[w]) begin
        word_q[w] <= word_d[w];
      end
    end

    for (genvar k = 0; k < 4; k++) begin : g_field
      assign cfg_o[4*w+k] = word_q[w][8*k +: 4];
    end
  end

  // control, table base, scratch
  logic [31:0] ctrl_q, ctrl_d, vbase_q, vbase_d, scr_q, scr_d;
  logic        ctrl_we, vbase_we, scr_we;

  assign ctrl_we  = wr_en && (blk == BLK_CTRL);
  assign vbase_we = wr_en && (blk == BLK_VBASE);
  assign scr_we   = wr_en && (blk == BLK_SCRATCH);

  always_comb begin
    ctrl_d  = acc_apply(ctrl_q,  wdata, mode) & CTRL_MASK;
    vbase_d = acc_apply(vbase_q, wdata, mode) & VBASE_MASK;
    scr_d   = acc_apply(scr_q,   wdata, mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      vbase_q <= '0;
      scr_q   <= '0;
    end else begin
      if (ctrl_we)  ctrl_q  <= ctrl_d;
      if (vbase_we) vbase_q <= vbase_d;
      if (scr_we)   scr_q   <= scr_d;
    end
  end

  assign irq_en_o  = ctrl_q[CTRL_IRQ_EN_BIT];
  assign rd_mode_o = ctrl_q[CTRL_RD_ACK_BIT];
  assign no_nest_o = ctrl_q[CTRL_NO_NEST_BIT];
  assign vbase_o   = vbase_q[31:2];

  always_comb begin
    rdata_o = '0;
    hit_o   = 1'b0;
    if (blk == BLK_CTRL) begin
      rdata_o = ctrl_q;
      hit_o   = 1'b1;
    end else if (blk == BLK_VBASE) begin
      rdata_o = vbase_q;
      hit_o   = 1'b1;
    end else if (blk == BLK_SCRATCH) begin
      rdata_o = scr_q;
      hit_o   = 1'b1;
    end else begin
      for (int w = 0; w < NWORD; w++) begin
        if (blk == BLK_CFG0 + BLK_W'(w)) begin
          rdata_o = word_q[w];
          hit_o   = 1'b1;
        end
      end
    end
  end

  // R2: a masked register never holds bits outside its field map
  a_r2_fields_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_q & ~CTRL_MASK) == '0) && (vbase_q[1:0] == 2'b00));

endmodule

// File: rtl/icoll_pend.sv
module icoll_pend #(
  parameter int unsigned NSRC = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] soft_i,
  input  logic [NSRC-1:0] drop_i,
  input  logic [NSRC-1:0] svc_i,
  output logic [NSRC-1:0] pend_o
);

  logic [NSRC-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = ((pend_q & en_i) | (en_i & (req_i | soft_i))) & ~drop_i & ~svc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R6: a dropped source is not pending in the following cycle
  a_r6_drop_discards: assert property (@(posedge clk) disable iff (!rst_n)
    (|drop_i) |=> ((pend_q & $past(drop_i)) == '0));

  // R5: nothing becomes pending without its enable
  a_r5_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(en_i)) == '0) || $past(!rst_n));

endmodule

// File: rtl/icoll_arb.sv
module icoll_arb #(
  parameter int unsigned NSRC = 64,
  parameter int unsigned PW   = 2,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]          elig_i,
  input  logic [NSRC-1:0][PW-1:0]  prio_i,
  output logic                     valid_o,
  output logic [IDX_W-1:0]         idx_o,
  output logic [PW-1:0]            prio_o
);

  // Scan from the top index down; ">=" lets a lower index take a tie.
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig_i[i] && (!valid_o || (prio_i[i] >= prio_o))) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i];
      end
    end
  end

  // R5: the winner is always one of the eligible sources
  always_comb begin
    if (valid_o) begin
      a_r5_pick_eligible: assert (elig_i[idx_o]);
    end
  end

endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import icoll_pkg::*;
#(
  parameter int unsigned NSRC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [6:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   req_in,
  output logic              irq_out
);

  localparam int unsigned IDX_W = $clog2(NSRC);
  localparam int unsigned PW    = 2;
  localparam int unsigned LVL_N = 1 << PW;

  // reset: asserted at once, released through two flops
  logic rst_m_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_n <= rst_m_q;
    end
  end

  logic [BLK_W-1:0] blk;
  assign blk = bus_addr[ADDR_W-1:2];

  // configuration registers
  logic [NSRC-1:0][3:0] cfg;
  logic                 irq_en, rd_mode, no_nest;
  logic [31:2]          vbase;
  logic [31:0]          rf_rdata;
  logic                 rf_hit;

  icoll_regfile #(.NSRC(NSRC)) u_regs (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wr_en    (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .cfg_o    (cfg),
    .irq_en_o (irq_en),
    .rd_mode_o(rd_mode),
    .no_nest_o(no_nest),
    .vbase_o  (vbase),
    .rdata_o  (rf_rdata),
    .hit_o    (rf_hit)
  );

  logic [NSRC-1:0]         src_en, src_soft, drop;
  logic [NSRC-1:0][PW-1:0] src_prio;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign src_prio[i] = cfg[i][PW-1:0];
    assign src_en[i]   = cfg[i][2];
    assign src_soft[i] = cfg[i][3];
    assign drop[i]     = bus_wr && (blk == BLK_DROP_LO + BLK_W'(i / 32))
                         && bus_wdata[i % 32];
  end

  // pending latch and arbitration
  logic [NSRC-1:0]  pend, svc;
  logic             best_valid;
  logic [IDX_W-1:0] best_idx;
  logic [PW-1:0]    best_prio;

  icoll_pend #(.NSRC(NSRC)) u_pend (
    .clk   (clk),
    .rst_n (rst_s_n),
    .req_i (req_in),
    .en_i  (src_en),
    .soft_i(src_soft),
    .drop_i(drop),
    .svc_i (svc),
    .pend_o(pend)
  );

  icoll_arb #(.NSRC(NSRC), .PW(PW)) u_arb (
    .elig_i (pend),
    .prio_i (src_prio),
    .valid_o(best_valid),
    .idx_o  (best_idx),
    .prio_o (best_prio)
  );

  // in-service tracking and active source
  logic [LVL_N-1:0] inserv_q, inserv_d, ack_mask;
  logic [IDX_W-1:0] act_q, act_d;
  logic [PW-1:0]    act_prio;
  logic             blocked, irq_cond, vec_blk, ack_wr, ev;

  always_comb begin
    blocked = no_nest && (|inserv_q);
    for (int l = 0; l < LVL_N; l++) begin
      if (inserv_q[l] && (PW'(l) >= best_prio)) begin
        blocked = 1'b1;
      end
    end
    irq_cond = best_valid && !blocked;
  end

  assign irq_out  = irq_en && irq_cond;
  assign act_prio = src_prio[act_q];
  assign vec_blk  = (blk == BLK_VECTOR);
  assign ack_wr   = bus_wr && (blk == BLK_LVLACK);
  assign ack_mask = ack_wr ? bus_wdata[LVL_N-1:0] : '0;
  assign ev       = irq_out && vec_blk &&
                    ((bus_wr && !rd_mode) || (bus_rd && rd_mode));
  assign svc      = ev ? (NSRC'(1) << act_q) : '0;

  always_comb begin
    inserv_d = inserv_q & ~ack_mask;
    if (ev) begin
      inserv_d[act_prio] = 1'b1;
    end
    act_d = irq_cond ? best_idx : act_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      inserv_q <= '0;
      act_q    <= '0;
    end else begin
      if (ev || ack_wr) inserv_q <= inserv_d;
      if (irq_cond)     act_q    <= act_d;
    end
  end

  // read data
  always_comb begin
    bus_rdata = '0;
    if (rf_hit) begin
      bus_rdata = rf_rdata;
    end else begin
      unique case (blk)
        BLK_VECTOR: bus_rdata = {vbase + 30'(act_q), 2'b00};
        BLK_LVLACK: bus_rdata = 32'(inserv_q);
        BLK_STAT:   bus_rdata = 32'(act_q);
        BLK_RAW_LO: bus_rdata = req_in[31:0];
        BLK_RAW_HI: bus_rdata = req_in[63:32];
        default:    bus_rdata = '0;
      endcase
    end
  end

  // R8: in-service flags move only on an entry event or an acknowledge write
  a_r8_inserv_moves_on_events: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!ev && !ack_wr) |=> $stable(inserv_q));

  // R11: acknowledged levels are clear afterwards
  a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ack_wr && !ev) |=> ((inserv_q & $past(bus_wdata[LVL_N-1:0])) == '0));

  // R12: the reported source holds while no request may pass
  a_r12_active_held: assert property (@(posedge clk) disable iff (!rst_s_n)
    !irq_cond |=> $stable(act_q));

  // R10: with nesting off, an entry event leaves the line low next cycle
  a_r10_no_nest_after_entry: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ev && no_nest && !ack_wr && !bus_wr) |=> !irq_out);

endmodule

// File: tb/sim_irq_collector.sv
module sim_irq_collector;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata;
  wire  [31:0] bus_rdata;
  logic [63:0] req_in;
  wire         irq_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_collector u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .req_in   (req_in),
    .irq_out  (irq_out)
  );

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a[8:2];
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a[8:2];
    bus_rd   = 1'b1;
    #2;
    d = bus_rdata;
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  function automatic logic [8:0] cfg_addr(input int n);
    return 9'h060 + 9'((n / 4) * 16);
  endfunction

  function automatic logic [31:0] field(input int n, input logic [3:0] v);
    return 32'(v) << (8 * (n % 4));
  endfunction

  task automatic clear_all();
    for (int w = 0; w < 16; w++) wr(9'h060 + 9'(w * 16), 32'h0);
    wr(9'h1D0, 32'hFFFF_FFFF);
    wr(9'h1E0, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d, s, vb;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; req_in = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
    rd(9'h020, d); chk("R1 ctrl", d, 32'h0);
    rd(9'h030, d); chk("R1 status", d, 32'h0);
    rd(9'h010, d); chk("R1 in-service", d, 32'h0);
    rd(9'h160, d); chk("R1 table base", d, 32'h0);
    rd(9'h1F0, d); chk("R1 scratch", d, 32'h0);
    for (int w = 0; w < 16; w++) begin
      rd(9'h060 + 9'(w * 16), d); chk("R1 source field word", d, 32'h0);
    end

    // R13 scratch and R2 aliases
    s = 32'hDEAD_BEEF; wr(9'h1F0, s);
    rd(9'h1F0, d); chk("R13 scratch write", d, s);
    wr(9'h1F4, 32'h0000_0F00); s = s | 32'h0000_0F00;
    rd(9'h1F0, d); chk("R2 set alias", d, s);
    wr(9'h1F8, 32'hF000_0000); s = s & ~32'hF000_0000;
    rd(9'h1F0, d); chk("R2 clear alias", d, s);
    wr(9'h1FC, 32'h0000_00FF); s = s ^ 32'h0000_00FF;
    rd(9'h1F0, d); chk("R2 toggle alias", d, s);

    // R3 field layout sweep
    for (int w = 0; w < 16; w++) begin
      logic [31:0] p;
      p = 32'h9ABC_DEF1 ^ (32'(w) * 32'h0101_0101);
      wr(9'h060 + 9'(w * 16), p);
      rd(9'h060 + 9'(w * 16), d); chk("R3 field readback", d, p & 32'h0F0F_0F0F);
    end
    wr(9'h064, 32'h0000_0030);
    rd(9'h060, d); chk("R3 upper nibble ignored", d, (32'h9ABC_DEF1 & 32'h0F0F_0F0F));
    clear_all();

    // R4 raw view with nothing enabled
    req_in = 64'hA5A5_0F0F_1234_8001;
    rd(9'h040, d); chk("R4 raw low", d, 32'h1234_8001);
    rd(9'h050, d); chk("R4 raw high", d, 32'hA5A5_0F0F);
    idle(2);
    chk("R4 disabled sources keep irq low", {31'b0, irq_out}, 32'h0);
    req_in = '0;

    // R7 table base
    wr(9'h160, 32'h1234_5677); vb = 32'h1234_5674;
    rd(9'h160, d); chk("R7 base low bits zero", d, vb);

    // R9 enable output, R5/R7 per-source sweep
    wr(9'h020, 32'h0001_0000);
    for (int n = 0; n < 64; n++) begin
      req_in = 64'b1 << n;
      wr(cfg_addr(n), field(n, 4'(4 | (n % 4))));
      idle(3);
      chk("R9 irq for lone source", {31'b0, irq_out}, 32'h1);
      rd(9'h030, d); chk("R5 status source number", d, 32'(n));
      rd(9'h000, d); chk("R7 vector address", d, vb + 32'(4 * n));
      wr(cfg_addr(n), 32'h0);
      req_in = '0;
      idle(2);
      chk("R5 disabled source idle", {31'b0, irq_out}, 32'h0);
    end

    // R5 arbitration with software triggers
    wr(cfg_addr(5),  field(5,  4'hD));
    wr(cfg_addr(9),  field(9,  4'hF));
    wr(cfg_addr(40), field(40, 4'hF));
    wr(cfg_addr(2),  field(2,  4'hC));
    idle(3);
    rd(9'h030, d); chk("R5 tie to lowest index", d, 32'd9);
    wr(cfg_addr(9), 32'h0); idle(2);
    rd(9'h030, d); chk("R5 next highest", d, 32'd40);
    wr(cfg_addr(40), 32'h0); idle(2);
    rd(9'h030, d); chk("R5 priority over index", d, 32'd5);
    wr(cfg_addr(5), 32'h0); idle(2);
    rd(9'h030, d); chk("R5 lowest priority last", d, 32'd2);
    clear_all(); idle(2);

    // R6 drop latched pulses
    wr(cfg_addr(12), field(12, 4'h4));
    @(negedge clk); req_in[12] = 1'b1;
    @(negedge clk); req_in[12] = 1'b0;
    idle(2);
    chk("R6 pulse latched", {31'b0, irq_out}, 32'h1);
    wr(9'h1D0, 32'h0000_1000);
    chk("R6 low word drop", {31'b0, irq_out}, 32'h0);
    wr(cfg_addr(45), field(45, 4'h4));
    @(negedge clk); req_in[45] = 1'b1;
    @(negedge clk); req_in[45] = 1'b0;
    idle(2);
    chk("R6 pulse latched high", {31'b0, irq_out}, 32'h1);
    wr(9'h1E0, 32'h0000_2000);
    chk("R6 high word drop", {31'b0, irq_out}, 32'h0);
    clear_all(); idle(2);

    // R8/R9/R11/R12 nesting, write-to-enter mode
    wr(cfg_addr(3), field(3, 4'hD));
    idle(3);
    rd(9'h030, d); chk("R9 first request", d, 32'd3);
    wr(9'h000, 32'h0);
    rd(9'h010, d); chk("R8 write enters level 1", d, 32'h2);
    chk("R9 same level blocked", {31'b0, irq_out}, 32'h0);
    wr(cfg_addr(20), field(20, 4'hE));
    idle(3);
    chk("R9 higher level preempts", {31'b0, irq_out}, 32'h1);
    wr(cfg_addr(30), field(30, 4'hC));
    idle(2);
    rd(9'h030, d); chk("R9 preempting source", d, 32'd20);
    wr(9'h000, 32'h0);
    rd(9'h010, d); chk("R8 nested level 2", d, 32'h6);
    wr(cfg_addr(20), 32'h0);
    wr(9'h010, 32'h4);
    rd(9'h010, d); chk("R11 ack level 2", d, 32'h2);
    chk("R9 lower levels blocked", {31'b0, irq_out}, 32'h0);
    rd(9'h030, d); chk("R12 status held", d, 32'd20);
    wr(9'h010, 32'h2);
    idle(2);
    chk("R11 ack reopens line", {31'b0, irq_out}, 32'h1);
    rd(9'h030, d); chk("R12 status follows winner", d, 32'd3);
    clear_all(); idle(2);

    // R8 read-to-enter mode
    wr(9'h020, 32'h0005_0000);
    wr(cfg_addr(7), field(7, 4'hE));
    idle(3);
    wr(9'h000, 32'h0);
    rd(9'h010, d); chk("R8 write ignored in read mode", d, 32'h0);
    chk("R8 line still up", {31'b0, irq_out}, 32'h1);
    rd(9'h000, d); chk("R7 vector in read mode", d, vb + 32'd28);
    rd(9'h010, d); chk("R8 read enters level 2", d, 32'h4);
    chk("R8 line down after entry", {31'b0, irq_out}, 32'h0);

    // R10 nesting disabled
    wr(9'h024, 32'h0008_0000);
    wr(cfg_addr(50), field(50, 4'hF));
    idle(3);
    chk("R10 higher level held off", {31'b0, irq_out}, 32'h0);
    wr(9'h010, 32'h4);
    idle(2);
    chk("R10 released after ack", {31'b0, irq_out}, 32'h1);
    rd(9'h030, d); chk("R10 winner", d, 32'd50);

    // R9 global enable with R2 control aliases
    wr(9'h028, 32'h0001_0000);
    chk("R9 global enable off", {31'b0, irq_out}, 32'h0);
    rd(9'h020, d); chk("R2 ctrl clear alias", d, 32'h000C_0000);
    wr(9'h02C, 32'h0001_0000);
    chk("R9 global enable on", {31'b0, irq_out}, 32'h1);
    rd(9'h020, d); chk("R2 ctrl toggle alias", d, 32'h000D_0000);

    finish_run();
  end

endmodule